// File: doc/BRIEF.md
# Two-Channel IDE I/O Port Decoder

This block sits between a host I/O bus and the two task-file channels of a PCI IDE controller. It decodes each I/O access, decides whether the access belongs to the controller, and sends registered strobes to the correct channel. The strobes carry the register offset and the write data.

The decoder has two addressing modes, selected by the low nibble of the programming-interface byte:
- **Compatibility mode.** Each channel answers at its fixed historical command-block and control-block ports, and the reported interrupt pin is 0.
- **Native mode.** The fixed ports are released. Each channel answers only at the base addresses supplied from configuration space, and the reported interrupt pin is 1.

Access size is taken into account. Byte accesses reach the task-file registers. Word and doubleword accesses at offset 0 are data-port transfers. The control block accepts only a byte at offset 2. Any other access inside a claimed window is unsupported:
- an unsupported read is answered by the decoder itself with all ones of the access width;
- an unsupported write is dropped.

Top module: `ide_port_decoder`

## Requirements
- R1: After reset the decoder is in compatibility mode, `intPin` is 0, and every strobe and `fillValid` and `claimed` output is low.
- R2: A `progIfValid` cycle with nibble 0x0 selects compatibility mode and a cycle with nibble 0xF selects native mode, effective from the next cycle. Any other nibble leaves the mode unchanged.
- R3: In compatibility mode the claimed windows are:
  - channel 0: command block 0x1F0–0x1F7 and control window 0x3F4–0x3F7;
  - channel 1: command block 0x170–0x177 and control window 0x374–0x377.

  In native mode none of these addresses is claimed unless a native base maps them.
- R4: `intPin` reads 0 in compatibility mode and 1 in native mode.
- R5: In native mode, each channel's command block is the 8-byte window at its `nativeCmdBase` with the low 3 bits ignored. Its control window is the 4-byte window at its `nativeCtlBase` with the low 2 bits ignored. Channel 0 wins if windows overlap.
- R6: A 1-byte access to a command block pulses `tfRd` or `tfWr` for that channel. `regOff` equals the address's low 3 bits. For writes, `wrData` carries `reqWdata`.
- R7: At command-block offset 0, size code 1 (2 bytes) pulses `d16Rd`/`d16Wr` and size code 2 (4 bytes) pulses `d32Rd`/`d32Wr`.
- R8: Only a 1-byte access at control-window offset 2 pulses `ctlRd`/`ctlWr`, with `regOff` = 2.
- R9: Any other access inside a claimed window is unsupported:
  - a read gives `fillValid` with `fillData` equal to 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2, and 0xFFFFFFFF for code 3;
  - a write gives no strobe and no fill.
- R10: `claimed` is high for every access inside a claimed window, supported or not. An access outside every window produces no output at all.
- R11: All decode outputs appear exactly one cycle after the request and last one cycle. At most one strobe is high at a time, and never together with `fillValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progIfValid | input | 1 | Programming-interface byte written this cycle |
| progIf | input | 4 | Low nibble of programming-interface byte |
| nativeCmdBase0 | input | 16 | Channel 0 native command-block base |
| nativeCtlBase0 | input | 16 | Channel 0 native control-window base |
| nativeCmdBase1 | input | 16 | Channel 1 native command-block base |
| nativeCtlBase1 | input | 16 | Channel 1 native control-window base |
| reqValid | input | 1 | I/O access present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | I/O byte address |
| reqSize | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = invalid |
| reqWdata | input | 32 | Write data |
| tfRd | output | 2 | Task-file register read strobe per channel |
| tfWr | output | 2 | Task-file register write strobe per channel |
| d16Rd | output | 2 | 16-bit data-port read strobe per channel |
| d16Wr | output | 2 | 16-bit data-port write strobe per channel |
| d32Rd | output | 2 | 32-bit data-port read strobe per channel |
| d32Wr | output | 2 | 32-bit data-port write strobe per channel |
| ctlRd | output | 2 | Alternate-status read strobe per channel |
| ctlWr | output | 2 | Device-control write strobe per channel |
| regOff | output | 3 | Register offset for the strobe |
| wrData | output | 32 | Write data accompanying a write strobe |
| fillValid | output | 1 | Decoder answers an unsupported read |
| fillData | output | 32 | All-ones fill for the access width |
| claimed | output | 1 | Access fell inside a claimed window |
| nativeMode | output | 1 | 1 = native addressing active |
| intPin | output | 8 | Interrupt-pin value to report |

## Verification
A wrong mode bit shows up in the first access after the nibble write: a legacy port is still claimed, or a native base is missed, and `intPin` is wrong in that same cycle. A bad size or offset decode shows up one cycle after the offending access. It appears as a strobe on the wrong line or channel, or as a missing or wrongly masked fill. The bench mixes seeded random addresses near every window edge with directed accesses. Each response is compared against a model of the windows and access rules.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_TF   = 3'd1,
    ACC_D16  = 3'd2,
    ACC_D32  = 3'd3,
    ACC_CTL  = 3'd4,
    ACC_FILL = 3'd5
  } accKind_e;

  typedef struct packed {
    accKind_e   kind;
    logic       hit;
    logic       isWrite;
    logic       chan;
    logic [2:0] off;
    logic [1:0] size;
  } decStrobe_t;

  function automatic logic [31:0] widthMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    widthMask = 32'h0000_00FF;
      2'd1:    widthMask = 32'h0000_FFFF;
      default: widthMask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LEG_CMD0 = 'h1F0,
  parameter logic [ADDR_W-1:0] LEG_CTL0 = 'h3F4,
  parameter logic [ADDR_W-1:0] LEG_CMD1 = 'h170,
  parameter logic [ADDR_W-1:0] LEG_CTL1 = 'h374
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progIfValid,
  input  logic [3:0]        progIf,
  input  logic [ADDR_W-1:0] nativeCmdBase0,
  input  logic [ADDR_W-1:0] nativeCtlBase0,
  input  logic [ADDR_W-1:0] nativeCmdBase1,
  input  logic [ADDR_W-1:0] nativeCtlBase1,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output logic              nativeMode,
  output decStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CMD_MASK = ~(ADDR_W'(7));
  localparam logic [ADDR_W-1:0] CTL_MASK = ~(ADDR_W'(3));
  localparam int NUM_CH = 2;

  // Mode register: only the two defined nibbles change it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nativeMode <= 1'b0;
    end else if (progIfValid) begin
      if (progIf == 4'h0)      nativeMode <= 1'b0;
      else if (progIf == 4'hF) nativeMode <= 1'b1;
    end
  end

  logic [ADDR_W-1:0] cmdBaseSel [NUM_CH];
  logic [ADDR_W-1:0] ctlBaseSel [NUM_CH];

  always_comb begin
    cmdBaseSel[0] = nativeMode ? nativeCmdBase0 : LEG_CMD0;
    ctlBaseSel[0] = nativeMode ? nativeCtlBase0 : LEG_CTL0;
    cmdBaseSel[1] = nativeMode ? nativeCmdBase1 : LEG_CMD1;
    ctlBaseSel[1] = nativeMode ? nativeCtlBase1 : LEG_CTL1;
  end

  logic       anyHit;
  logic       isCmd;
  logic       hitChan;

  // Channel 0 is scanned last so it wins any overlap.
  always_comb begin
    anyHit  = 1'b0;
    isCmd   = 1'b0;
    hitChan = 1'b0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if ((reqAddr & CTL_MASK) == (ctlBaseSel[ch] & CTL_MASK)) begin
        anyHit  = 1'b1;
        isCmd   = 1'b0;
        hitChan = ch[0];
      end
      if ((reqAddr & CMD_MASK) == (cmdBaseSel[ch] & CMD_MASK)) begin
        anyHit  = 1'b1;
        isCmd   = 1'b1;
        hitChan = ch[0];
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.kind    = ACC_NONE;
    strobe.isWrite = reqWrite;
    strobe.chan    = hitChan;
    strobe.size    = reqSize;
    strobe.off     = isCmd ? reqAddr[2:0] : {1'b0, reqAddr[1:0]};
    if (reqValid && anyHit) begin
      strobe.hit = 1'b1;
      if (isCmd) begin
        if (reqSize == 2'd0)                               strobe.kind = ACC_TF;
        else if (reqAddr[2:0] == 3'd0 && reqSize == 2'd1)  strobe.kind = ACC_D16;
        else if (reqAddr[2:0] == 3'd0 && reqSize == 2'd2)  strobe.kind = ACC_D32;
        else                                               strobe.kind = reqWrite ? ACC_NONE : ACC_FILL;
      end else begin
        if (reqAddr[1:0] == 2'd2 && reqSize == 2'd0)       strobe.kind = ACC_CTL;
        else                                               strobe.kind = reqWrite ? ACC_NONE : ACC_FILL;
      end
    end
  end

  p_mode_native_r2: assert property (@(posedge clk) disable iff (!rstN)
    (progIfValid && progIf == 4'hF) |=> nativeMode);
  p_mode_legacy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (progIfValid && progIf == 4'h0) |=> !nativeMode);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!progIfValid || (progIf != 4'h0 && progIf != 4'hF)) |=> $stable(nativeMode));
  p_write_no_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> strobe.kind != ACC_FILL);

endmodule

// File: rtl/ide_dec_datapath.sv
module ide_dec_datapath
  import ide_dec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strobe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [NUM_CH-1:0] tfRd,
  output logic [NUM_CH-1:0] tfWr,
  output logic [NUM_CH-1:0] d16Rd,
  output logic [NUM_CH-1:0] d16Wr,
  output logic [NUM_CH-1:0] d32Rd,
  output logic [NUM_CH-1:0] d32Wr,
  output logic [NUM_CH-1:0] ctlRd,
  output logic [NUM_CH-1:0] ctlWr,
  output logic [2:0]        regOff,
  output logic [DATA_W-1:0] wrData,
  output logic              fillValid,
  output logic [DATA_W-1:0] fillData,
  output logic              claimed
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic sel;
    assign sel = (strobe.chan == ch[0]);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tfRd[ch]  <= 1'b0;  tfWr[ch]  <= 1'b0;
        d16Rd[ch] <= 1'b0;  d16Wr[ch] <= 1'b0;
        d32Rd[ch] <= 1'b0;  d32Wr[ch] <= 1'b0;
        ctlRd[ch] <= 1'b0;  ctlWr[ch] <= 1'b0;
      end else begin
        tfRd[ch]  <= sel && strobe.kind == ACC_TF  && !strobe.isWrite;
        tfWr[ch]  <= sel && strobe.kind == ACC_TF  &&  strobe.isWrite;
        d16Rd[ch] <= sel && strobe.kind == ACC_D16 && !strobe.isWrite;
        d16Wr[ch] <= sel && strobe.kind == ACC_D16 &&  strobe.isWrite;
        d32Rd[ch] <= sel && strobe.kind == ACC_D32 && !strobe.isWrite;
        d32Wr[ch] <= sel && strobe.kind == ACC_D32 &&  strobe.isWrite;
        ctlRd[ch] <= sel && strobe.kind == ACC_CTL && !strobe.isWrite;
        ctlWr[ch] <= sel && strobe.kind == ACC_CTL &&  strobe.isWrite;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regOff    <= '0;
      wrData    <= '0;
      fillValid <= 1'b0;
      fillData  <= '0;
      claimed   <= 1'b0;
    end else begin
      regOff    <= strobe.off;
      wrData    <= strobe.isWrite ? reqWdata : '0;
      fillValid <= (strobe.kind == ACC_FILL);
      fillData  <= (strobe.kind == ACC_FILL) ? DATA_W'(widthMask(strobe.size)) : '0;
      claimed   <= strobe.hit;
    end
  end

  logic [8*NUM_CH-1:0] allStrobes;
  assign allStrobes = {tfRd, tfWr, d16Rd, d16Wr, d32Rd, d32Wr, ctlRd, ctlWr};

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $countones(allStrobes) <= 1);
  p_fill_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> allStrobes == '0);
  p_fill_claimed_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> claimed);
  p_strobe_claimed_r10: assert property (@(posedge clk) disable iff (!rstN)
    (allStrobes != '0) |-> claimed);
  p_ctl_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlRd | ctlWr) != '0) |-> regOff == 3'd2);

endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        progIfValid,
  input  logic [3:0]  progIf,
  input  logic [15:0] nativeCmdBase0,
  input  logic [15:0] nativeCtlBase0,
  input  logic [15:0] nativeCmdBase1,
  input  logic [15:0] nativeCtlBase1,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic [31:0] reqWdata,
  output logic [1:0]  tfRd,
  output logic [1:0]  tfWr,
  output logic [1:0]  d16Rd,
  output logic [1:0]  d16Wr,
  output logic [1:0]  d32Rd,
  output logic [1:0]  d32Wr,
  output logic [1:0]  ctlRd,
  output logic [1:0]  ctlWr,
  output logic [2:0]  regOff,
  output logic [31:0] wrData,
  output logic        fillValid,
  output logic [31:0] fillData,
  output logic        claimed,
  output logic        nativeMode,
  output logic [7:0]  intPin
);

  decStrobe_t strobe;

  ide_dec_ctrl #(.ADDR_W(16)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .progIfValid(progIfValid), .progIf(progIf),
    .nativeCmdBase0(nativeCmdBase0), .nativeCtlBase0(nativeCtlBase0),
    .nativeCmdBase1(nativeCmdBase1), .nativeCtlBase1(nativeCtlBase1),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .nativeMode(nativeMode), .strobe(strobe)
  );

  ide_dec_datapath #(.DATA_W(32), .NUM_CH(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWdata(reqWdata),
    .tfRd(tfRd), .tfWr(tfWr), .d16Rd(d16Rd), .d16Wr(d16Wr),
    .d32Rd(d32Rd), .d32Wr(d32Wr), .ctlRd(ctlRd), .ctlWr(ctlWr),
    .regOff(regOff), .wrData(wrData), .fillValid(fillValid),
    .fillData(fillData), .claimed(claimed)
  );

  assign intPin = {7'd0, nativeMode};

endmodule

// File: tb/tb_ide_port_decoder.sv
module tb_ide_port_decoder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        progIfValid = 1'b0;
  logic [3:0]  progIf = '0;
  logic [15:0] nCmd0 = 16'hC000, nCtl0 = 16'hC010, nCmd1 = 16'hC020, nCtl1 = 16'hC034;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  tfRd, tfWr, d16Rd, d16Wr, d32Rd, d32Wr, ctlRd, ctlWr;
  logic [2:0]  regOff;
  logic [31:0] wrData, fillData;
  logic        fillValid, claimed, nativeMode;
  logic [7:0]  intPin;

  ide_port_decoder dut (
    .clk(clk), .rstN(rstN), .progIfValid(progIfValid), .progIf(progIf),
    .nativeCmdBase0(nCmd0), .nativeCtlBase0(nCtl0),
    .nativeCmdBase1(nCmd1), .nativeCtlBase1(nCtl1),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata),
    .tfRd(tfRd), .tfWr(tfWr), .d16Rd(d16Rd), .d16Wr(d16Wr),
    .d32Rd(d32Rd), .d32Wr(d32Wr), .ctlRd(ctlRd), .ctlWr(ctlWr),
    .regOff(regOff), .wrData(wrData), .fillValid(fillValid),
    .fillData(fillData), .claimed(claimed), .nativeMode(nativeMode), .intPin(intPin)
  );

  int  nTests = 0;
  int  nFails = 0;
  bit  modelNative = 1'b0;
  bit  finished = 1'b0;

  // Expected output bundle: 16 strobe bits, regOff, fillValid, fillData, claimed
  typedef struct packed {
    logic [15:0] strb;
    logic [2:0]  off;
    logic        fill;
    logic [31:0] fdata;
    logic        clm;
  } outs_t;

  function automatic outs_t actual();
    outs_t a;
    a.strb  = {tfRd, tfWr, d16Rd, d16Wr, d32Rd, d32Wr, ctlRd, ctlWr};
    a.off   = regOff;
    a.fill  = fillValid;
    a.fdata = fillData;
    a.clm   = claimed;
    return a;
  endfunction

  function automatic logic [31:0] maskFor(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit inWin(input logic [15:0] a, input logic [15:0] b, input int len);
    int lo;
    lo = int'(b) - (int'(b) % len);
    return int'(a) >= lo && int'(a) < lo + len;
  endfunction

  // strobe bit index: group g (0 tf,1 d16,2 d32,3 ctl), read/write, channel
  function automatic int bitIdx(input int g, input bit wr, input int ch);
    return 15 - (g * 4 + (wr ? 2 : 0) + (1 - ch));
  endfunction

  function automatic outs_t model(input bit wr, input logic [15:0] a, input logic [1:0] s,
                                  output string tag);
    outs_t e;
    logic [15:0] cb [2];
    logic [15:0] kb [2];
    int ch;
    bit isCmd, hit;
    int off;
    e = '0;
    cb[0] = modelNative ? nCmd0 : 16'h1F0;  kb[0] = modelNative ? nCtl0 : 16'h3F4;
    cb[1] = modelNative ? nCmd1 : 16'h170;  kb[1] = modelNative ? nCtl1 : 16'h374;
    hit = 0; isCmd = 0; ch = 0;
    if (inWin(a, cb[0], 8))      begin hit = 1; isCmd = 1; ch = 0; end
    else if (inWin(a, kb[0], 4)) begin hit = 1; isCmd = 0; ch = 0; end
    else if (inWin(a, cb[1], 8)) begin hit = 1; isCmd = 1; ch = 1; end
    else if (inWin(a, kb[1], 4)) begin hit = 1; isCmd = 0; ch = 1; end
    off = isCmd ? int'(a % 8) : int'(a % 4);
    e.off = 3'(off);
    tag = modelNative ? "R5/R10" : "R3/R10";
    if (!hit) return e;
    e.clm = 1'b1;
    if (isCmd && s == 2'd0) begin
      e.strb[bitIdx(0, wr, ch)] = 1'b1; tag = "R6";
    end else if (isCmd && off == 0 && s == 2'd1) begin
      e.strb[bitIdx(1, wr, ch)] = 1'b1; tag = "R7";
    end else if (isCmd && off == 0 && s == 2'd2) begin
      e.strb[bitIdx(2, wr, ch)] = 1'b1; tag = "R7";
    end else if (!isCmd && off == 2 && s == 2'd0) begin
      e.strb[bitIdx(3, wr, ch)] = 1'b1; tag = "R8";
    end else begin
      tag = "R9";
      if (!wr) begin e.fill = 1'b1; e.fdata = maskFor(s); end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setMode(input logic [3:0] nib);
    @(negedge clk);
    progIfValid = 1'b1; progIf = nib;
    @(negedge clk);
    progIfValid = 1'b0;
    if (nib == 4'h0) modelNative = 1'b0;
    else if (nib == 4'hF) modelNative = 1'b1;
    check(nativeMode == modelNative, "R2 mode", 64'(nativeMode), 64'(modelNative));
    check(intPin == {7'd0, modelNative}, "R4 intPin", 64'(intPin), 64'(modelNative));
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [1:0] s, input logic [31:0] d);
    outs_t e, g;
    string tag;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = s; reqWdata = d;
    e = model(wr, a, s, tag);
    @(negedge clk);
    reqValid = 1'b0;
    g = actual();
    if (e.strb == '0) g.off = e.off;  // offset only meaningful with a strobe
    check(g == e, tag, {16'(a), 14'(g.strb), 1'(g.fill), g.fdata[15:0], 1'(g.clm), 16'(g.off)},
          {16'(a), 14'(e.strb), 1'(e.fill), e.fdata[15:0], 1'(e.clm), 16'(e.off)});
    if (wr && e.strb != '0)
      check(wrData == d, "R6 wrData", 64'(wrData), 64'(d));
    // R11: one-cycle pulse
    @(negedge clk);
    check(actual() == '0 || (actual().strb == '0 && !actual().fill && !actual().clm),
          "R11 pulse", 64'(actual().strb), 64'(0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nTests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    logic [15:0] bases [8];
    seed = 12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(actual() == '0, "R1 outputs", 64'(actual().strb), 64'(0));
    check(nativeMode == 1'b0 && intPin == 8'd0, "R1 mode", 64'(intPin), 64'(0));
    rstN = 1'b1;
    @(negedge clk);

    // directed legacy
    access(1'b0, 16'h3F6, 2'd0, 0);            // R8 ctl read ch0
    access(1'b1, 16'h376, 2'd0, 32'h04);       // R8 ctl write ch1
    access(1'b0, 16'h3F4, 2'd0, 0);            // R9 fill 0xFF
    access(1'b0, 16'h1F0, 2'd2, 0);            // R7 d32
    access(1'b1, 16'h170, 2'd1, 32'hBEEF);     // R7 d16 write ch1
    access(1'b1, 16'h1F7, 2'd0, 32'hEC);       // R6 tf write
    access(1'b0, 16'h1F1, 2'd1, 0);            // R9 fill 0xFFFF
    access(1'b0, 16'h1F0, 2'd3, 0);            // R9 invalid size
    access(1'b1, 16'h1F2, 2'd2, 32'h1234);     // R9 ignored write
    access(1'b0, 16'h1F8, 2'd0, 0);            // R10 miss
    setMode(4'hF);                             // R2 native, R4
    access(1'b0, 16'h1F0, 2'd0, 0);            // R3 released
    access(1'b0, 16'h3F6, 2'd0, 0);            // R3 released
    access(1'b0, 16'hC012, 2'd0, 0);           // R5 native ctl ch0
    access(1'b1, 16'hC025, 2'd0, 32'h5A);      // R5 native cmd ch1
    setMode(4'h5);                             // R2 hold native
    access(1'b0, 16'hC036, 2'd0, 0);           // R5 still native
    setMode(4'h0);                             // R2 legacy

    bases[0] = 16'h1F0; bases[1] = 16'h3F4; bases[2] = 16'h170; bases[3] = 16'h374;
    bases[4] = nCmd0;   bases[5] = nCtl0;   bases[6] = nCmd1;   bases[7] = nCtl1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      if ($urandom % 16 == 0) setMode(4'($urandom));
      a = bases[$urandom % 8] + 16'($urandom % 10) - 16'd1;
      access(1'($urandom), a, 2'($urandom), $urandom);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule